// File: doc/BRIEF.md
# Converter Power-Mode Controller

This block decides when the core of a serial successive-approximation converter is powered, when its internal reference runs, and whether the serial port stays usable. It watches a three-level shutdown pin, which arrives already decoded as a 2-bit code. It also watches three pulses from the serial front end: one when a start bit is detected, one when a control byte is complete, and one when a conversion finishes.

A start bit wakes the core. The control byte then opens a conversion and supplies two bits. The first says whether to stay powered after the conversion; the second says whether the conversion is clocked by the serial clock or by the internal oscillator. A software power-down waits for the running conversion to end. A hard shutdown from the pin cuts power at the next clock edge and flags the lost conversion with a one-cycle abort pulse.

A wake counter stands in for reference settling. It holds back a ready flag for a fixed number of cycles after each power-up. A strobe level shows when an internally clocked conversion is in flight.

Top module: `pm_ctrl`

## Requirements
- R1: After reset, with the shutdown code not low, the outputs are as follows: core power off, reference off, ready low, abort low, interface enable high, and strobe high. The clock mode resets to internal.
- R2: A start pulse powers the core on at the next edge, unless the shutdown code is 00 (low). While the code is 00, start pulses have no effect.
- R3: The ready flag rises exactly WAKE_CYCLES edges after the core power enable rises. It is low whenever the core is off.
- R4: Shutdown code 00 turns the core, the reference and the interface off at the next edge. If a conversion was in flight, conv_abort goes high for exactly one cycle.
- R5: The reference enable is high only while the core is on and the shutdown code is 01 (floating). With code 10 (driven high), the reference is off, but the core still powers up and becomes ready.
- R6: A control byte with its stay bit (ctrl_pd1) at 0 keeps the core on until conv_done arrives. The core then switches off at that edge.
- R7: A control byte with its stay bit at 1 keeps the core on after conv_done.
- R8: The clock-mode bit is ctrl_pd0, where 1 means serial-clock mode and 0 means internal mode. strobe_hi is low only while an internal-mode conversion is in flight.
- R9: While a conversion is in flight, a further control byte is ignored. The running conversion keeps the clock mode and stay bit of the byte that started it.
- R10: With the core off and the shutdown code not 00, iface_en follows the last clock mode: high if it was internal, so the stored result stays readable, and low if it was serial-clock.
- R11: Shutdown code 11 is treated the same as code 01 (floating).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_code | input | 2 | Decoded shutdown pin: 00 low, 01 float, 10 high, 11 float |
| start_pulse | input | 1 | One-cycle pulse when a start bit is seen |
| ctrl_valid | input | 1 | One-cycle pulse when a control byte is complete |
| ctrl_pd1 | input | 1 | Stay-powered bit of the control byte |
| ctrl_pd0 | input | 1 | Clock-mode bit of the control byte (1 serial clock) |
| conv_done | input | 1 | One-cycle pulse at the end of a conversion |
| core_pwr_en | output | 1 | Converter core power enable |
| ref_en | output | 1 | Internal reference enable |
| conv_abort | output | 1 | One-cycle pulse when a conversion is cut off |
| iface_en | output | 1 | Serial interface enable |
| core_ready | output | 1 | Core powered and settled |
| strobe_hi | output | 1 | Strobe level, low during an internal-mode conversion |

## Verification
The power sequence is driven with control bytes covering all four combinations of stay and clock-mode bits. This separates software power-down from staying on, and internal from serial-clock strobe and interface behaviour. A second control byte during a conversion shows whether the latched settings are protected. Hard shutdown is applied in the middle of a conversion and also ahead of a start pulse, which distinguishes an immediate abort from a deferred power-down. Each of the three non-low shutdown codes is applied in turn to show how the reference is gated, and the ready flag is sampled one cycle before and at its expected rise.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    SHDN_LOW   = 2'b00,
    SHDN_FLOAT = 2'b01,
    SHDN_HIGH  = 2'b10,
    SHDN_RSVD  = 2'b11
  } shdn_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_IDLE = 2'b01,
    ST_CONV = 2'b10
  } pm_state_e;

  typedef struct packed {
    logic hard;    // force full power-down
    logic ref_ok;  // reference may run
  } shdn_dec_t;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pm_shdn_dec.sv
module pm_shdn_dec
  import pm_pkg::*;
(
  input  logic [1:0] code,
  output shdn_dec_t  dec
);
  always_comb begin
    dec = '0;
    unique case (shdn_e'(code))
      SHDN_LOW:   dec.hard   = 1'b1;
      SHDN_HIGH:  dec.ref_ok = 1'b0;
      SHDN_FLOAT,
      SHDN_RSVD:  dec.ref_ok = 1'b1;
      default:    dec        = '0;
    endcase
  end
endmodule

// File: rtl/pm_wake_timer.sv
module pm_wake_timer #(
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ready
);
  localparam int CW = (WAKE_CYCLES < 1) ? 1 : $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIMIT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = run && (cnt_q == LIMIT);
endmodule

// File: rtl/pm_seq.sv
module pm_seq
  import pm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hard,
  input  logic start_pulse,
  input  logic ctrl_valid,
  input  logic ctrl_stay,
  input  logic ctrl_ext,
  input  logic conv_done,
  output logic core_on,
  output logic busy,
  output logic ext_mode,
  output logic abort
);
  pm_state_e state_q, state_d;
  logic      ext_q, ext_d, stay_q, stay_d, abort_q, abort_d, cfg_en;

  always_comb begin
    state_d = state_q;
    ext_d   = ext_q;
    stay_d  = stay_q;
    cfg_en  = 1'b0;
    abort_d = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        if (!hard && start_pulse) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (hard) begin
          state_d = ST_OFF;
        end else if (ctrl_valid) begin
          state_d = ST_CONV;
          cfg_en  = 1'b1;
          ext_d   = ctrl_ext;
          stay_d  = ctrl_stay;
        end
      end
      ST_CONV: begin
        if (hard) begin
          state_d = ST_OFF;
          abort_d = 1'b1;
        end else if (conv_done) begin
          state_d = (stay_q || start_pulse) ? ST_IDLE : ST_OFF;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      stay_q <= 1'b0;
    end else if (cfg_en) begin
      ext_q  <= ext_d;
      stay_q <= stay_d;
    end
  end

  assign core_on  = (state_q != ST_OFF);
  assign busy     = (state_q == ST_CONV);
  assign ext_mode = ext_q;
  assign abort    = abort_q;
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int WAKE_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] shdn_code,
  input  logic       start_pulse,
  input  logic       ctrl_valid,
  input  logic       ctrl_pd1,
  input  logic       ctrl_pd0,
  input  logic       conv_done,
  output logic       core_pwr_en,
  output logic       ref_en,
  output logic       conv_abort,
  output logic       iface_en,
  output logic       core_ready,
  output logic       strobe_hi
);
  logic      rst_sync_n;
  shdn_dec_t dec;
  logic      core_on, busy, ext_mode, abort;

  pm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  pm_shdn_dec u_dec (.code(shdn_code), .dec(dec));

  pm_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .hard(dec.hard),
    .start_pulse(start_pulse), .ctrl_valid(ctrl_valid),
    .ctrl_stay(ctrl_pd1), .ctrl_ext(ctrl_pd0), .conv_done(conv_done),
    .core_on(core_on), .busy(busy), .ext_mode(ext_mode), .abort(abort)
  );

  pm_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk(clk), .rst_n(rst_sync_n), .run(core_on), .ready(core_ready)
  );

  assign core_pwr_en = core_on;
  assign ref_en      = core_on && dec.ref_ok;
  assign conv_abort  = abort;
  assign iface_en    = !dec.hard && (core_on || !ext_mode);
  assign strobe_hi   = !(busy && !ext_mode);
endmodule

// File: rtl/pm_ctrl_chk.sv
module pm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] shdn_code,
  input logic       start_pulse,
  input logic       conv_done,
  input logic       core_pwr_en,
  input logic       ref_en,
  input logic       conv_abort,
  input logic       core_ready
);
  p_hard_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_code == 2'b00) |=> !core_pwr_en);

  p_abort_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> !conv_abort);

  p_start_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && shdn_code != 2'b00) |=> core_pwr_en);

  p_ready_needs_core_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |-> core_pwr_en);

  p_ref_high_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (shdn_code == 2'b10) |-> !ref_en);

  p_hold_until_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_pwr_en && !conv_done && shdn_code != 2'b00) |=> core_pwr_en);
endmodule

bind pm_ctrl pm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .shdn_code(shdn_code),
  .start_pulse(start_pulse), .conv_done(conv_done),
  .core_pwr_en(core_pwr_en), .ref_en(ref_en), .conv_abort(conv_abort),
  .core_ready(core_ready)
);

// File: tb/pm_ctrl_bench.sv
`timescale 1ns/1ps
module pm_ctrl_bench;
  localparam int WAKE = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] shdn_code;
  logic       start_pulse, ctrl_valid, ctrl_pd1, ctrl_pd0, conv_done;
  logic       core_pwr_en, ref_en, conv_abort, iface_en, core_ready, strobe_hi;
  int         n_run = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  pm_ctrl #(.WAKE_CYCLES(WAKE)) u_pm_ctrl (
    .clk(clk), .rst_n(rst_n), .shdn_code(shdn_code),
    .start_pulse(start_pulse), .ctrl_valid(ctrl_valid),
    .ctrl_pd1(ctrl_pd1), .ctrl_pd0(ctrl_pd0), .conv_done(conv_done),
    .core_pwr_en(core_pwr_en), .ref_en(ref_en), .conv_abort(conv_abort),
    .iface_en(iface_en), .core_ready(core_ready), .strobe_hi(strobe_hi)
  );

  task automatic check(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] code);
    rst_n = 1'b0; shdn_code = code;
    start_pulse = 0; ctrl_valid = 0; ctrl_pd1 = 0; ctrl_pd0 = 0; conv_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_start();
    start_pulse = 1'b1; @(negedge clk); start_pulse = 1'b0;
  endtask

  task automatic pulse_ctrl(logic pd1, logic pd0);
    ctrl_pd1 = pd1; ctrl_pd0 = pd0; ctrl_valid = 1'b1;
    @(negedge clk); ctrl_valid = 1'b0;
  endtask

  task automatic pulse_done();
    conv_done = 1'b1; @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'b01);
    check("R1 core", core_pwr_en, 0);
    check("R1 ref", ref_en, 0);
    check("R1 ready", core_ready, 0);
    check("R1 abort", conv_abort, 0);
    check("R1 iface", iface_en, 1);
    check("R1 strobe", strobe_hi, 1);
  endtask

  task automatic t_wake();
    do_reset(2'b01);
    pulse_start();
    check("R2 core on", core_pwr_en, 1);
    check("R5 ref float", ref_en, 1);
    check("R3 ready early", core_ready, 0);
    repeat (WAKE - 1) @(negedge clk);
    check("R3 ready one before", core_ready, 0);
    @(negedge clk);
    check("R3 ready rise", core_ready, 1);
  endtask

  task automatic t_soft_int();
    do_reset(2'b01);
    pulse_start();
    pulse_ctrl(1'b0, 1'b0);
    check("R8 strobe low internal", strobe_hi, 0);
    repeat (3) @(negedge clk);
    check("R6 held until done", core_pwr_en, 1);
    pulse_done();
    check("R6 off after done", core_pwr_en, 0);
    check("R8 strobe back high", strobe_hi, 1);
    check("R3 ready drops", core_ready, 0);
    check("R10 iface internal", iface_en, 1);
  endtask

  task automatic t_soft_ext();
    do_reset(2'b01);
    pulse_start();
    pulse_ctrl(1'b0, 1'b1);
    check("R8 strobe high serial", strobe_hi, 1);
    pulse_done();
    check("R6 off serial", core_pwr_en, 0);
    check("R10 iface serial off", iface_en, 0);
  endtask

  task automatic t_stay();
    do_reset(2'b01);
    pulse_start();
    pulse_ctrl(1'b1, 1'b0);
    pulse_done();
    check("R7 stays on", core_pwr_en, 1);
    check("R7 strobe idle", strobe_hi, 1);
  endtask

  task automatic t_ctrl_ignored();
    do_reset(2'b01);
    pulse_start();
    pulse_ctrl(1'b0, 1'b0);
    pulse_ctrl(1'b1, 1'b1);
    check("R9 mode kept", strobe_hi, 0);
    pulse_done();
    check("R9 stay bit kept", core_pwr_en, 0);
  endtask

  task automatic t_hard();
    do_reset(2'b01);
    pulse_start();
    pulse_ctrl(1'b1, 1'b0);
    shdn_code = 2'b00;
    @(negedge clk);
    check("R4 core off", core_pwr_en, 0);
    check("R4 abort", conv_abort, 1);
    check("R4 ref off", ref_en, 0);
    check("R4 iface off", iface_en, 0);
    @(negedge clk);
    check("R4 abort single", conv_abort, 0);
    pulse_start();
    check("R2 start ignored low", core_pwr_en, 0);
    shdn_code = 2'b01;
    @(negedge clk);
    check("R4 stays off", core_pwr_en, 0);
  endtask

  task automatic t_ref_high();
    do_reset(2'b10);
    pulse_start();
    check("R5 core on high", core_pwr_en, 1);
    check("R5 ref off high", ref_en, 0);
    repeat (WAKE) @(negedge clk);
    check("R5 ready high", core_ready, 1);
  endtask

  task automatic t_code3();
    do_reset(2'b11);
    pulse_start();
    check("R11 core on", core_pwr_en, 1);
    check("R11 ref on", ref_en, 1);
  endtask

  initial begin
    t_reset();
    t_wake();
    t_soft_int();
    t_soft_ext();
    t_stay();
    t_ctrl_ignored();
    t_hard();
    t_ref_high();
    t_code3();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule